// File: doc/BRIEF.md
# Multi-Mode DMA Address Generator

This block produces the byte-address sequence for one side, read or write, of a DMA transfer. A configuration is captured with a single load strobe: start address, element size code, elements per frame, frames per block, a signed element skip, a signed frame skip, an address mode and a repeat count. After the load, every advance strobe presents the current address on the output and moves the address register to the next location in the same clock edge.

Five address patterns are offered: a fixed address (for a peripheral data register), incrementing and decrementing by the element size, a strided 1D walk, and a 2D walk that adds a second, frame-level skip only when it crosses a frame boundary. Frame-end and block-end outputs are raised in the same cycle as the advance that presents the last address of a frame or of a block. When repetitions are configured, each new pass starts again from the captured start address. A done output is raised once the final pass has completed.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is held, and after it until the first load, busy_o, done_o, frame_end_o and block_end_o are 0 and addr_o is 0.
- R2: One cycle after load_i is sampled high, addr_o equals the loaded start address, busy_o is 1 and done_o is 0. A load also restarts a transfer that is already running.
- R3: With mode code 0 (fixed), every address of the transfer equals the start address. Mode codes 5 to 7 are not defined and behave like mode 0.
- R4: The size code selects the element size as 2^code bytes (0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8). Mode code 1 adds the element size after each advance. Mode code 2 subtracts it.
- R5: Mode code 3 (1D stride) adds the element size plus the signed element skip after every advance.
- R6: Mode code 4 (2D) adds the element size plus the element skip inside a frame. After the last element of a frame it also adds the signed frame skip. The address of element e in frame f is start + (f*N + e)*(size + element skip) + f*frame skip, where N is the number of elements per frame.
- R7: frame_end_o is 1 exactly during an accepted advance whose presented address is the last element of a frame.
- R8: block_end_o is 1 exactly during the accepted advance of the last element of the last frame. It never occurs without frame_end_o.
- R9: After a block end with passes remaining, addr_o returns to the start address, and the element and frame counts start again from zero.
- R10: The repeat count is read as a 16-bit two's complement value. 0 runs a single pass, n > 0 runs n+1 passes, and any negative value repeats without end. One cycle after the final block end, done_o is 1 and busy_o is 0.
- R11: All address arithmetic wraps modulo 2^32.
- R12: An advance while busy_o is 0 has no effect: addr_o does not change and no end flag is raised.
- R13: An element or frame count of zero behaves as a count of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Capture the configuration and start a transfer |
| cfg_start_i | input | 32 | Start byte address |
| cfg_size_i | input | 2 | Element size code, size = 2^code bytes |
| cfg_mode_i | input | 3 | Address mode code |
| cfg_elems_i | input | 16 | Elements per frame |
| cfg_frames_i | input | 16 | Frames per block |
| cfg_eskip_i | input | 32 | Signed element skip in bytes |
| cfg_fskip_i | input | 32 | Signed frame skip in bytes |
| cfg_repeat_i | input | 16 | Signed repeat count |
| adv_i | input | 1 | Advance strobe |
| addr_o | output | 32 | Current address |
| frame_end_o | output | 1 | Last element of a frame is being presented |
| block_end_o | output | 1 | Last element of a block is being presented |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | The final pass has finished |

## Verification
On every cycle the assertions check the local step rules: the fixed mode holds the address, the incrementing mode adds exactly one element size, a block end always comes with a frame end, a block end returns the address to the start or ends the transfer, done_o and busy_o exclude each other, and the address does not move while idle. The closed-form address of each element in 2D and 1D walks with negative skips, the wrap past 2^32, repeat counting including the endless case, and the treatment of zero counts are visible only across whole scenarios, so the bench compares every presented address and flag against a formula indexed by pass, frame and element.

// File: rtl/dag_pkg.sv
package dag_pkg;

  typedef enum logic [2:0] {
    AM_FIXED  = 3'd0,
    AM_INCR   = 3'd1,
    AM_DECR   = 3'd2,
    AM_STRIDE = 3'd3,
    AM_GRID   = 3'd4
  } amode_e;

  localparam int unsigned SIZE_CODE_W = 2;

endpackage

// File: rtl/dag_rst_sync.sv
module dag_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dag_count.sv
module dag_count #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          last
);

  logic [CW-1:0] cnt_q, cnt_d;

  // a limit of zero or one makes every position the last one
  assign last = (limit <= CW'(1)) || (cnt_q == limit - CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = last ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dag_step.sv
module dag_step
  import dag_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0]          addr,
  input  logic [2:0]             mode,
  input  logic [SIZE_CODE_W-1:0] size_code,
  input  logic [AW-1:0]          eskip,
  input  logic [AW-1:0]          fskip,
  input  logic                   frame_last,
  output logic [AW-1:0]          next_addr
);

  logic [AW-1:0] esz;
  logic [AW-1:0] stride;

  assign esz    = AW'(1) << size_code;
  assign stride = esz + eskip;

  always_comb begin
    unique case (mode)
      AM_INCR:   next_addr = addr + esz;
      AM_DECR:   next_addr = addr - esz;
      AM_STRIDE: next_addr = addr + stride;
      AM_GRID:   next_addr = frame_last ? addr + stride + fskip : addr + stride;
      default:   next_addr = addr;
    endcase
  end

endmodule

// File: rtl/dag_repeat.sv
module dag_repeat #(
  parameter int unsigned RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [RW-1:0] cfg_repeat,
  input  logic          block_fire,
  output logic          more
);

  logic [RW-1:0] rem_q, rem_d;
  logic          endless_q, endless_d;

  assign more = endless_q || (rem_q != '0);

  always_comb begin
    rem_d     = rem_q;
    endless_d = endless_q;
    if (load) begin
      rem_d     = cfg_repeat;
      endless_d = cfg_repeat[RW-1];
    end else if (block_fire && !endless_q && rem_q != '0) begin
      rem_d = rem_q - RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q     <= '0;
      endless_q <= 1'b0;
    end else begin
      rem_q     <= rem_d;
      endless_q <= endless_d;
    end
  end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dag_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16,
  parameter int unsigned RW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [AW-1:0]          cfg_start_i,
  input  logic [SIZE_CODE_W-1:0] cfg_size_i,
  input  logic [2:0]             cfg_mode_i,
  input  logic [CW-1:0]          cfg_elems_i,
  input  logic [CW-1:0]          cfg_frames_i,
  input  logic [AW-1:0]          cfg_eskip_i,
  input  logic [AW-1:0]          cfg_fskip_i,
  input  logic [RW-1:0]          cfg_repeat_i,
  input  logic                   adv_i,
  output logic [AW-1:0]          addr_o,
  output logic                   frame_end_o,
  output logic                   block_end_o,
  output logic                   busy_o,
  output logic                   done_o
);

  logic rst_sync_n;

  dag_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // captured configuration
  logic [AW-1:0]          start_q;
  logic [SIZE_CODE_W-1:0] size_q;
  logic [2:0]             mode_q;
  logic [CW-1:0]          elems_q, frames_q;
  logic [AW-1:0]          eskip_q, fskip_q;

  // run state
  logic [AW-1:0] addr_q, addr_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;

  logic adv_ok, elem_last, frame_last, block_last, block_fire, more;
  logic [AW-1:0] step_addr;

  assign adv_ok     = adv_i && busy_q && !load_i;
  assign block_last = elem_last && frame_last;
  assign block_fire = adv_ok && block_last;

  dag_count #(.CW(CW)) u_elem_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (load_i),
    .en    (adv_ok),
    .limit (elems_q),
    .last  (elem_last)
  );

  dag_count #(.CW(CW)) u_frame_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (load_i),
    .en    (adv_ok && elem_last),
    .limit (frames_q),
    .last  (frame_last)
  );

  dag_repeat #(.RW(RW)) u_rep (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (load_i),
    .cfg_repeat (cfg_repeat_i),
    .block_fire (block_fire),
    .more       (more)
  );

  dag_step #(.AW(AW)) u_step (
    .addr       (addr_q),
    .mode       (mode_q),
    .size_code  (size_q),
    .eskip      (eskip_q),
    .fskip      (fskip_q),
    .frame_last (elem_last),
    .next_addr  (step_addr)
  );

  // next-state logic
  always_comb begin
    addr_d = addr_q;
    busy_d = busy_q;
    done_d = done_q;
    if (load_i) begin
      addr_d = cfg_start_i;
      busy_d = 1'b1;
      done_d = 1'b0;
    end else if (block_fire) begin
      if (more) begin
        addr_d = start_q;
      end else begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (adv_ok) begin
      addr_d = step_addr;
    end
  end

  // configuration capture, enabled by load
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      start_q  <= '0;
      size_q   <= '0;
      mode_q   <= '0;
      elems_q  <= '0;
      frames_q <= '0;
      eskip_q  <= '0;
      fskip_q  <= '0;
    end else if (load_i) begin
      start_q  <= cfg_start_i;
      size_q   <= cfg_size_i;
      mode_q   <= cfg_mode_i;
      elems_q  <= cfg_elems_i;
      frames_q <= cfg_frames_i;
      eskip_q  <= cfg_eskip_i;
      fskip_q  <= cfg_fskip_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign addr_o      = addr_q;
  assign frame_end_o = adv_ok && elem_last;
  assign block_end_o = block_fire;
  assign busy_o      = busy_q;
  assign done_o      = done_q;

endmodule

// File: rtl/dag_checker.sv
module dag_checker
  import dag_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic                   clk,
  input logic                   rst_q,
  input logic                   load_i,
  input logic [AW-1:0]          cfg_start_i,
  input logic                   adv_i,
  input logic [AW-1:0]          addr_o,
  input logic                   frame_end_o,
  input logic                   block_end_o,
  input logic                   busy_o,
  input logic                   done_o,
  input logic [2:0]             mode_q,
  input logic [SIZE_CODE_W-1:0] size_q,
  input logic [AW-1:0]          start_q
);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_q)
    load_i |=> (addr_o == $past(cfg_start_i)) && busy_o && !done_o);

  p_fixed_hold_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (busy_o && adv_i && !load_i && mode_q == AM_FIXED) |=> $stable(addr_o));

  p_incr_step_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (busy_o && adv_i && !load_i && mode_q == AM_INCR && !block_end_o)
      |=> addr_o == $past(addr_o) + (AW'(1) << size_q));

  p_frame_on_adv_r7: assert property (@(posedge clk) disable iff (!rst_q)
    frame_end_o |-> (adv_i && busy_o));

  p_block_nested_r8: assert property (@(posedge clk) disable iff (!rst_q)
    block_end_o |-> frame_end_o);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_q)
    block_end_o |=> (addr_o == start_q) || done_o);

  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |-> !busy_o);

  p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(done_o) |-> $past(block_end_o));

  p_idle_still_r12: assert property (@(posedge clk) disable iff (!rst_q)
    (!busy_o && !load_i) |=> $stable(addr_o));

  p_idle_noflag_r12: assert property (@(posedge clk) disable iff (!rst_q)
    !busy_o |-> !frame_end_o);

endmodule

bind dma_addr_gen dag_checker #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_q       (rst_sync_n),
  .load_i      (load_i),
  .cfg_start_i (cfg_start_i),
  .adv_i       (adv_i),
  .addr_o      (addr_o),
  .frame_end_o (frame_end_o),
  .block_end_o (block_end_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mode_q      (mode_q),
  .size_q      (size_q),
  .start_q     (start_q)
);

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [2:0]  mode;
    logic [1:0]  size;
    logic [31:0] start;
    logic [15:0] elems;
    logic [15:0] frames;
    logic [31:0] eskip;
    logic [31:0] fskip;
    logic [15:0] rep;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{3'd1, 2'd2, 32'h0000_1000, 16'd4, 16'd2, 32'd0,          32'd0,          16'd0},
    '{3'd2, 2'd1, 32'h0000_2000, 16'd3, 16'd2, 32'd0,          32'd0,          16'd1},
    '{3'd0, 2'd3, 32'h0000_3000, 16'd2, 16'd3, 32'd0,          32'd0,          16'd0},
    '{3'd3, 2'd0, 32'h0000_4000, 16'd5, 16'd1, 32'd3,          32'd0,          16'd0},
    '{3'd4, 2'd2, 32'h0000_5000, 16'd3, 16'd3, 32'd4,          32'h40,         16'd1},
    '{3'd4, 2'd1, 32'h0000_6000, 16'd2, 16'd2, 32'hFFFF_FFFA,  32'hFFFF_FFE0,  16'd0},
    '{3'd1, 2'd3, 32'hFFFF_FFF0, 16'd4, 16'd1, 32'd0,          32'd0,          16'd0},
    '{3'd3, 2'd0, 32'h0000_0010, 16'd0, 16'd0, 32'd1,          32'd0,          16'd2},
    '{3'd7, 2'd2, 32'h0000_7000, 16'd2, 16'd2, 32'd0,          32'd0,          16'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_i, adv_i;
  logic [31:0] cfg_start_i, cfg_eskip_i, cfg_fskip_i;
  logic [1:0]  cfg_size_i;
  logic [2:0]  cfg_mode_i;
  logic [15:0] cfg_elems_i, cfg_frames_i, cfg_repeat_i;
  logic [31:0] addr_o;
  logic        frame_end_o, block_end_o, busy_o, done_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_gen u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .cfg_start_i  (cfg_start_i),
    .cfg_size_i   (cfg_size_i),
    .cfg_mode_i   (cfg_mode_i),
    .cfg_elems_i  (cfg_elems_i),
    .cfg_frames_i (cfg_frames_i),
    .cfg_eskip_i  (cfg_eskip_i),
    .cfg_fskip_i  (cfg_fskip_i),
    .cfg_repeat_i (cfg_repeat_i),
    .adv_i        (adv_i),
    .addr_o       (addr_o),
    .frame_end_o  (frame_end_o),
    .block_end_o  (block_end_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // closed-form address of element e of frame f (R3..R6, R11, R13)
  function automatic logic [31:0] model_addr(input vec_t v, input int f, input int e);
    logic [31:0] esz, k, ff;
    int n;
    n   = (v.elems == 0) ? 1 : int'(v.elems);
    esz = 32'd1 << v.size;
    k   = 32'(f * n + e);
    ff  = 32'(f);
    case (v.mode)
      3'd1:    return v.start + k * esz;
      3'd2:    return v.start - k * esz;
      3'd3:    return v.start + k * (esz + v.eskip);
      3'd4:    return v.start + k * (esz + v.eskip) + ff * v.fskip;
      default: return v.start;
    endcase
  endfunction

  task automatic do_load(input vec_t v);
    cfg_mode_i   = v.mode;
    cfg_size_i   = v.size;
    cfg_start_i  = v.start;
    cfg_elems_i  = v.elems;
    cfg_frames_i = v.frames;
    cfg_eskip_i  = v.eskip;
    cfg_fskip_i  = v.fskip;
    cfg_repeat_i = v.rep;
    load_i = 1'b1;
    @(posedge clk); #1;
    load_i = 1'b0;
  endtask

  // one advance: drive after an edge, sample at the falling edge, then let it commit
  task automatic step(input logic [31:0] exp_a, input logic exp_fe, input logic exp_be, input string req);
    adv_i = 1'b1;
    @(negedge clk);
    chk(req, addr_o, exp_a);
    chk("R7 frame_end", {31'd0, frame_end_o}, {31'd0, exp_fe});
    chk("R8 block_end", {31'd0, block_end_o}, {31'd0, exp_be});
    @(posedge clk); #1;
    adv_i = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int n, nf, passes;
    string req;
    n  = (v.elems  == 0) ? 1 : int'(v.elems);
    nf = (v.frames == 0) ? 1 : int'(v.frames);
    passes = int'(v.rep) + 1;
    case (v.mode)
      3'd0:    req = "R3 fixed";
      3'd1:    req = (idx == 6) ? "R11 wrap" : "R4 incr";
      3'd2:    req = "R4 decr";
      3'd3:    req = (idx == 7) ? "R13 zero counts" : "R5 stride";
      3'd4:    req = "R6 grid";
      default: req = "R3 undefined mode";
    endcase
    do_load(v);
    @(negedge clk);
    chk("R2 start addr", addr_o, v.start);
    chk("R2 busy", {31'd0, busy_o}, 32'd1);
    @(posedge clk); #1;
    for (int p = 0; p < passes; p++) begin
      for (int f = 0; f < nf; f++) begin
        for (int e = 0; e < n; e++) begin
          step(model_addr(v, f, e), e == n - 1, (e == n - 1) && (f == nf - 1),
               (p > 0 && f == 0 && e == 0) ? "R9 restart" : req);
        end
      end
    end
    @(negedge clk);
    chk("R10 done", {31'd0, done_o}, 32'd1);
    chk("R10 busy low", {31'd0, busy_o}, 32'd0);
    @(posedge clk); #1;
  endtask

  initial begin
    vec_t v;
    logic [31:0] held;
    rst_n = 1'b0; load_i = 1'b0; adv_i = 1'b0;
    cfg_start_i = '0; cfg_size_i = '0; cfg_mode_i = '0; cfg_elems_i = '0;
    cfg_frames_i = '0; cfg_eskip_i = '0; cfg_fskip_i = '0; cfg_repeat_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1: reset state
    @(negedge clk);
    chk("R1 busy", {31'd0, busy_o}, 32'd0);
    chk("R1 done", {31'd0, done_o}, 32'd0);
    chk("R1 addr", addr_o, 32'd0);
    chk("R1 block_end", {31'd0, block_end_o}, 32'd0);
    @(posedge clk); #1;

    // R12: advance before any load is ignored
    adv_i = 1'b1;
    @(negedge clk);
    chk("R12 idle flag", {31'd0, frame_end_o}, 32'd0);
    @(posedge clk); #1;
    adv_i = 1'b0;
    @(negedge clk);
    chk("R12 idle addr", addr_o, 32'd0);
    @(posedge clk); #1;

    // table walk
    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

    // R12: advance after done leaves address and done unchanged
    held = addr_o;
    adv_i = 1'b1;
    @(negedge clk);
    chk("R12 after done flag", {31'd0, block_end_o}, 32'd0);
    @(posedge clk); #1;
    adv_i = 1'b0;
    @(negedge clk);
    chk("R12 after done addr", addr_o, held);
    chk("R12 after done", {31'd0, done_o}, 32'd1);
    @(posedge clk); #1;

    // R10: negative repeat count runs without end
    v = '{3'd1, 2'd0, 32'h0000_0100, 16'd2, 16'd1, 32'd0, 32'd0, 16'hFFFF};
    do_load(v);
    for (int p = 0; p < 4; p++) begin
      step(32'h100, 1'b0, 1'b0, "R10 endless");
      step(32'h101, 1'b1, 1'b1, "R10 endless");
    end
    @(negedge clk);
    chk("R10 endless busy", {31'd0, busy_o}, 32'd1);
    chk("R10 endless done", {31'd0, done_o}, 32'd0);
    @(posedge clk); #1;

    // R2: load while running restarts from the new start
    step(32'h100, 1'b0, 1'b0, "R10 endless");
    v = '{3'd2, 2'd2, 32'h0000_0800, 16'd2, 16'd1, 32'd0, 32'd0, 16'd0};
    do_load(v);
    step(32'h800, 1'b0, 1'b0, "R2 reload");
    step(32'h7FC, 1'b1, 1'b1, "R2 reload");
    @(negedge clk);
    chk("R2 reload done", {31'd0, done_o}, 32'd1);
    @(posedge clk); #1;

    // R1: reset in mid-transfer clears state
    v = '{3'd1, 2'd0, 32'h0000_0900, 16'd8, 16'd1, 32'd0, 32'd0, 16'd0};
    do_load(v);
    step(32'h900, 1'b0, 1'b0, "R4 incr");
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset busy", {31'd0, busy_o}, 32'd0);
    chk("R1 mid reset addr", addr_o, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule